// File: doc/BRIEF.md
# Mode-Switched Parallel Port Group

This block holds four 8-bit parallel ports (B, C, F and G) behind a small register bus. The operating mode is captured while reset is asserted and stays fixed until the next reset. In the single-chip and bootstrap modes the ports are general-purpose I/O. Ports B and F are fixed outputs. Port C and port G have per-bit direction control, where a direction bit of 1 selects output and 0 selects input.

In the expanded and test modes the ports carry the external bus instead. Port B drives the high address byte and port F drives the low address byte. Port C becomes the bidirectional data bus, and its direction follows the read/write strobe. Bit 7 of port G becomes a program chip-select output. The data registers of ports B, F and C are then removed from the register map. The address, the write data, the strobe and the chip-select level are generated elsewhere and arrive here as inputs. Every pin output and output enable is registered.

Top module: `mux_io_ports`

## Requirements
- R1: While `rst_n` is low, every pin output, every output enable and `pg_cs_out` is 0. After reset, reads at offsets 0x03, 0x04, 0x05 and 0x07 return 0x00.
- R2: `mode_in` is sampled only while `rst_n` is low. The encodings are 00 single-chip, 01 bootstrap, 10 expanded and 11 test; bit 1 set selects a bus mode. Changing `mode_in` after reset is released has no effect.
- R3: In single-chip and bootstrap modes, `pb_oe` and `pf_oe` are all ones. `pb_out` and `pf_out` show the registers written at offsets 0x04 and 0x05, and reads at those offsets return the written values.
- R4: In bus modes, `pb_out` equals `ext_addr[15:8]` and `pf_out` equals `ext_addr[7:0]` one clock after they are presented, with `pb_oe` and `pf_oe` all ones.
- R5: In bus modes, offsets 0x04, 0x05 and 0x06 read 0x00 and ignore writes. An offset that no register uses reads 0x00 in every mode.
- R6: In single-chip and bootstrap modes, `pc_oe` equals the port C direction register at offset 0x07 and `pc_out` equals the latch at offset 0x06. Each bit read at 0x06 returns the latch where its direction bit is 1, and otherwise the pin level after a two-flop synchronizer.
- R7: In bus modes, `pc_out` equals `ext_dout`. `pc_oe` is all ones when `ext_rnw` is 0 and all zeros when it is 1, one clock later. `ext_din` returns `pc_in` through the two-flop synchronizer.
- R8: `pg_oe` equals the port G direction register at offset 0x03. In bus modes bit 7 of `pg_oe` is forced to 1 and `pg_cs_out` follows `ext_cs`, while the register still reads back the value written to it. In the other modes `pg_cs_out` is 0.
- R9: The direction registers at 0x03 and 0x07 are decoded in every mode and read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; mode is sampled while low |
| mode_in | input | 2 | Operating mode selection |
| reg_addr | input | 6 | Register offset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ext_addr | input | 16 | External address from the bus controller |
| ext_dout | input | 8 | Data to drive on port C during bus writes |
| ext_rnw | input | 1 | 1 = bus read, 0 = bus write |
| ext_cs | input | 1 | Program chip-select level |
| ext_din | output | 8 | Synchronized port C pin data for bus reads |
| pb_out | output | 8 | Port B pin values |
| pb_oe | output | 8 | Port B output enables |
| pf_out | output | 8 | Port F pin values |
| pf_oe | output | 8 | Port F output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C pin values |
| pc_oe | output | 8 | Port C output enables |
| pg_oe | output | 8 | Port G output enables |
| pg_cs_out | output | 1 | Port G bit 7 chip-select value |

## Verification
The assertions assume that `mode_in` settles before the first clock edge of reset and that register writes and pin changes only happen after reset is released. The bench changes `mode_in` only while `rst_n` is low, except for one deliberate change after release that checks the mode is held. The bench drives `pc_in` asynchronously to register accesses and waits out the synchronizer before it reads the pins. The assertions also assume that `ext_rnw` and `ext_dout` are meaningful on every cycle of a bus mode. The bench keeps them at defined levels throughout.

// File: rtl/mux_io_ports.sv
module mux_io_ports #(
  parameter int W  = 8,
  parameter int AW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_in,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [W-1:0]    reg_wdata,
  output logic [W-1:0]    reg_rdata,
  input  logic [2*W-1:0]  ext_addr,
  input  logic [W-1:0]    ext_dout,
  input  logic            ext_rnw,
  input  logic            ext_cs,
  output logic [W-1:0]    ext_din,
  output logic [W-1:0]    pb_out,
  output logic [W-1:0]    pb_oe,
  output logic [W-1:0]    pf_out,
  output logic [W-1:0]    pf_oe,
  input  logic [W-1:0]    pc_in,
  output logic [W-1:0]    pc_out,
  output logic [W-1:0]    pc_oe,
  output logic [W-1:0]    pg_oe,
  output logic            pg_cs_out
);
  localparam logic [AW-1:0] OFF_DIR_G = AW'(3);
  localparam logic [AW-1:0] OFF_DAT_B = AW'(4);
  localparam logic [AW-1:0] OFF_DAT_F = AW'(5);
  localparam logic [AW-1:0] OFF_DAT_C = AW'(6);
  localparam logic [AW-1:0] OFF_DIR_C = AW'(7);
  localparam logic [W-1:0]  ONES      = {W{1'b1}};

  logic [1:0]   mode_q;
  logic         bus_mode;
  logic [W-1:0] dir_g, dir_c, lat_b, lat_f, lat_c;
  logic [W-1:0] c_s1, c_s2;

  always_ff @(posedge clk)
    if (!rst_n) mode_q <= mode_in;

  assign bus_mode = mode_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_g <= '0;
      dir_c <= '0;
      lat_b <= '0;
      lat_f <= '0;
      lat_c <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFF_DIR_G: dir_g <= reg_wdata;
        OFF_DIR_C: dir_c <= reg_wdata;
        OFF_DAT_B: if (!bus_mode) lat_b <= reg_wdata;
        OFF_DAT_F: if (!bus_mode) lat_f <= reg_wdata;
        OFF_DAT_C: if (!bus_mode) lat_c <= reg_wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_s1 <= '0;
      c_s2 <= '0;
    end else begin
      c_s1 <= pc_in;
      c_s2 <= c_s1;
    end

  assign ext_din = c_s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pb_out    <= '0;
      pb_oe     <= '0;
      pf_out    <= '0;
      pf_oe     <= '0;
      pc_out    <= '0;
      pc_oe     <= '0;
      pg_oe     <= '0;
      pg_cs_out <= 1'b0;
    end else begin
      pb_oe <= ONES;
      pf_oe <= ONES;
      if (bus_mode) begin
        pb_out    <= ext_addr[2*W-1:W];
        pf_out    <= ext_addr[W-1:0];
        pc_out    <= ext_dout;
        pc_oe     <= ext_rnw ? '0 : ONES;
        pg_oe     <= dir_g | {1'b1, {(W-1){1'b0}}};
        pg_cs_out <= ext_cs;
      end else begin
        pb_out    <= lat_b;
        pf_out    <= lat_f;
        pc_out    <= lat_c;
        pc_oe     <= dir_c;
        pg_oe     <= dir_g;
        pg_cs_out <= 1'b0;
      end
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_DIR_G: reg_rdata = dir_g;
      OFF_DIR_C: reg_rdata = dir_c;
      OFF_DAT_B: if (!bus_mode) reg_rdata = lat_b;
      OFF_DAT_F: if (!bus_mode) reg_rdata = lat_f;
      OFF_DAT_C: if (!bus_mode) reg_rdata = (dir_c & lat_c) | (~dir_c & c_s2);
      default: ;
    endcase
  end

  p_fixed_out_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pb_oe == ONES && pf_oe == ONES));

  p_addr_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode && $past(rst_n)) |-> ({pb_out, pf_out} == $past(ext_addr)));

  p_hidden_regs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |=> ($stable(lat_b) && $stable(lat_f) && $stable(lat_c)));

  p_pc_dir_gp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_mode && $past(rst_n)) |-> (pc_oe == $past(dir_c)));

  p_pc_dir_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode && $past(rst_n)) |-> (pc_oe == ($past(ext_rnw) ? '0 : ONES)));

  p_cs_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode && $past(rst_n)) |-> (pg_oe[W-1] && pg_cs_out == $past(ext_cs)));

  p_cs_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_mode |-> !pg_cs_out);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (pb_oe == '0 && pf_oe == '0 && pc_oe == '0 && pg_oe == '0 && !pg_cs_out));
endmodule

// File: tb/test_mux_io_ports.sv
module test_mux_io_ports;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  mode_in = 2'b00;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] ext_addr = '0;
  logic [7:0]  ext_dout = '0;
  logic        ext_rnw = 1;
  logic        ext_cs = 0;
  logic [7:0]  ext_din;
  logic [7:0]  pb_out, pb_oe, pf_out, pf_oe, pc_out, pc_oe, pg_oe;
  logic [7:0]  pc_in = '0;
  logic        pg_cs_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { int sel; logic [7:0] val; string req; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  mux_io_ports i_mux_io_ports (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_rnw(ext_rnw), .ext_cs(ext_cs),
    .ext_din(ext_din), .pb_out(pb_out), .pb_oe(pb_oe), .pf_out(pf_out), .pf_oe(pf_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe), .pg_oe(pg_oe), .pg_cs_out(pg_cs_out)
  );

  function automatic logic [7:0] observe(int sel);
    case (sel)
      0: return reg_rdata;
      1: return pb_out;
      2: return pb_oe;
      3: return pf_out;
      4: return pf_oe;
      5: return pc_out;
      6: return pc_oe;
      7: return pg_oe;
      8: return {7'b0, pg_cs_out};
      default: return ext_din;
    endcase
  endfunction

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      logic [7:0] got;
      e = exp_q.pop_front();
      got = observe(e.sel);
      checks++;
      if (got !== e.val) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%02h expected=%02h", e.req, e.sel, got, e.val);
      end
    end
  end

  task automatic push(int sel, logic [7:0] v, string r);
    exp_t e;
    e.sel = sel; e.val = v; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic drive_slot();
    @(negedge clk); #1;
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    drive_slot();
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk);
    drive_slot();
    reg_wr = 0;
  endtask

  task automatic rd_expect(logic [5:0] a, logic [7:0] v, string r);
    drive_slot();
    reg_addr = a;
    @(posedge clk);
    push(0, v, r);
  endtask

  task automatic do_reset(logic [1:0] m);
    drive_slot();
    rst_n = 0; mode_in = m;
    settle(2);
    push(2, 8'h00, "R1 reset pb_oe");
    push(6, 8'h00, "R1 reset pc_oe");
    push(7, 8'h00, "R1 reset pg_oe");
    drive_slot();
    rst_n = 1;
    settle(2);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(2'b00);
    rd_expect(6'h03, 8'h00, "R1 ddr g");
    rd_expect(6'h04, 8'h00, "R1 port b");
    rd_expect(6'h05, 8'h00, "R1 port f");
    rd_expect(6'h07, 8'h00, "R1 ddr c");
    push(2, 8'hFF, "R3 pb_oe");
    push(4, 8'hFF, "R3 pf_oe");

    drive_slot(); ext_addr = 16'hBEEF; ext_cs = 1;
    wr(6'h04, 8'hA5);
    wr(6'h05, 8'h3C);
    settle(2);
    push(1, 8'hA5, "R3 pb_out");
    push(3, 8'h3C, "R3 pf_out");
    push(8, 8'h00, "R8 cs quiet");
    rd_expect(6'h04, 8'hA5, "R3 readback b");
    rd_expect(6'h05, 8'h3C, "R3 readback f");
    rd_expect(6'h00, 8'h00, "R5 unused offset");

    wr(6'h07, 8'h0F);
    wr(6'h06, 8'h96);
    drive_slot(); pc_in = 8'h5A;
    settle(3);
    push(6, 8'h0F, "R6 pc_oe");
    push(5, 8'h96, "R6 pc_out");
    rd_expect(6'h06, 8'h56, "R6 mixed read");
    rd_expect(6'h07, 8'h0F, "R9 ddr c");

    wr(6'h03, 8'h81);
    settle(2);
    push(7, 8'h81, "R8 pg_oe gp");
    rd_expect(6'h03, 8'h81, "R9 ddr g");

    do_reset(2'b01);
    push(2, 8'hFF, "R3 boot pb_oe");
    push(1, 8'h00, "R3 boot pb_out");
    push(7, 8'h00, "R8 boot pg_oe");

    drive_slot(); ext_addr = 16'h1234; ext_cs = 0; ext_rnw = 1;
    do_reset(2'b10);
    drive_slot(); mode_in = 2'b00;
    settle(2);
    push(1, 8'h12, "R4 pb addr");
    push(3, 8'h34, "R4 pf addr");
    push(4, 8'hFF, "R4 pf_oe");
    push(7, 8'h80, "R8 cs forced");
    rd_expect(6'h03, 8'h00, "R8 ddr g bit7 reads 0");
    rd_expect(6'h04, 8'h00, "R5 b hidden");
    wr(6'h04, 8'hFF);
    wr(6'h06, 8'hFF);
    rd_expect(6'h04, 8'h00, "R5 b write ignored");
    rd_expect(6'h06, 8'h00, "R5 c hidden");
    push(1, 8'h12, "R2 mode held");

    drive_slot(); ext_addr = 16'hA0B1;
    settle(2);
    push(1, 8'hA0, "R4 pb new addr");
    push(3, 8'hB1, "R4 pf new addr");

    wr(6'h03, 8'h01);
    drive_slot(); ext_cs = 1;
    settle(2);
    push(7, 8'h81, "R8 pg_oe bus");
    push(8, 8'h01, "R8 cs follows");
    rd_expect(6'h03, 8'h01, "R9 ddr g bus");

    drive_slot(); ext_rnw = 0; ext_dout = 8'hC3;
    settle(2);
    push(6, 8'hFF, "R7 drive on write");
    push(5, 8'hC3, "R7 data out");
    wr(6'h07, 8'hFF);
    drive_slot(); ext_rnw = 1; pc_in = 8'h77;
    settle(3);
    push(6, 8'h00, "R7 release on read");
    push(9, 8'h77, "R7 ext_din");
    rd_expect(6'h07, 8'hFF, "R9 ddr c bus");

    drive_slot(); ext_addr = 16'h4321;
    do_reset(2'b11);
    push(3, 8'h21, "R4 test mode pf");
    push(2, 8'hFF, "R4 test mode pb_oe");

    settle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule